// File: doc/BRIEF.md
# Burst-Aligned Serializer with Enable Path

This block is the transmit datapath of a burst-mode line interface. Parallel words arrive on a word strobe, each with a one-bit burst flag. The word and its flag are written together into one small shared FIFO. The serial side drains that FIFO, shifts each word out one bit per clock, most significant bit first, and presents the flag on a registered output. The flag output therefore changes in the same clock as the first bit of the word it came with, and a downstream laser driver switches on exactly at the start of the burst.

Both sides run on one clock. A parallel word is taken whenever the write strobe is high, and the serial side takes a new word every eight clocks. The serial side waits after a FIFO reset until two entries are queued, so that small differences between the write and read rates are absorbed. A FIFO reset input and a sticky FIFO error flag both blank the flag output, so no corrupt or stale data is sent while the queue is invalid.

Top module: `burst_ser_tx`

## Requirements
- R1: Each word leaves on `ser_out` most significant bit first, one bit per clock. The next word follows with no gap once its predecessor's least significant bit has been sent. The first bit appears in the clock after the word is taken from the FIFO.
- R2: `burst_out` carries the flag that was written with the word whose bits are currently on `ser_out`. It changes in the same clock as that word's first bit and holds for all eight bits.
- R3: After a global or FIFO reset, no word is read until the FIFO holds at least two entries. Until then `ser_out` and `burst_out` stay 0.
- R4: A write while the FIFO holds four entries and no read happens in the same clock is an overflow and sets `fifo_err` at the next clock edge. Four queued entries alone do not set it.
- R5: A word boundary reached while the FIFO is empty, after reading has started, is an underflow and sets `fifo_err` at the next clock edge.
- R6: While `fifo_err` is 1, `burst_out` and `ser_out` are 0.
- R7: In the clock after `fifo_rst` is sampled high, `fifo_err`, `burst_out` and `ser_out` are 0. A write presented while `fifo_rst` is high is discarded and never reaches `ser_out`.
- R8: Once set, `fifo_err` stays 1, and later writes have no effect on it, until `fifo_rst` is sampled high.
- R9: While and after `rst_n` is low, `ser_out`, `burst_out` and `fifo_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; the word strobe is qualified on it |
| rst_n | input | 1 | Asynchronous active-low global reset |
| fifo_rst | input | 1 | Synchronous FIFO reset; clears the queue and the error flag |
| wr_en | input | 1 | Word strobe; writes `wr_data` and `wr_burst` into the FIFO |
| wr_data | input | 8 | Parallel word to serialize |
| wr_burst | input | 1 | Burst flag belonging to `wr_data` |
| ser_out | output | 1 | Serial data, most significant bit first |
| burst_out | output | 1 | Registered burst flag, aligned to the first bit of its word |
| fifo_err | output | 1 | Sticky overflow or underflow indication |

## Verification
The hardest case to reach from the ports is the overflow boundary. The FIFO must be exactly full in a clock where the reader does not pop, and the reader's word boundary keeps moving while the queue fills. The stimulus gets there with an unbroken run of writes issued right after a FIFO reset. Counting the one pop made at start-up, the fifth write fills the queue without an error and the sixth overflows, so both sides of the boundary are checked. Underflow comes about on its own when a paced stream ends: a scoreboard compares every serial bit and flag against the queued words until the queue runs dry.

// File: rtl/bst_pkg.sv
`timescale 1ns/1ps
package bst_pkg;
   // Read-side sequencing of the serializer
   typedef enum logic [1:0] {
      RD_WAIT = 2'd0,   // filling after reset, no reads yet
      RD_RUN  = 2'd1,   // shifting words out
      RD_HALT = 2'd2    // frozen by an error until FIFO reset
   } rd_state_e;
endpackage

// File: rtl/bst_fifo.sv
`timescale 1ns/1ps
module bst_fifo #(
   parameter int unsigned EW    = 9,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [EW-1:0] push_word,
   output logic [EW-1:0] head_word,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

   logic [AW-1:0]       wptr_q;
   logic [AW-1:0]       rptr_q;
   logic [DEPTH*EW-1:0] slots_flat;

   // one register per entry; word and flag share the entry
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [EW-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (push && (wptr_q == AW'(i)))
            slot_q <= push_word;
      end
      assign slots_flat[i*EW +: EW] = slot_q;
   end

   assign head_word = slots_flat[rptr_q*EW +: EW];
   assign full      = (level == LVL_FULL);
   assign empty     = (level == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         level  <= '0;
      end else if (clr) begin
         wptr_q <= '0;
         rptr_q <= '0;
         level  <= '0;
      end else begin
         if (push) wptr_q <= wptr_q + 1'b1;
         if (pop)  rptr_q <= rptr_q + 1'b1;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/bst_rd_ctrl.sv
`timescale 1ns/1ps
module bst_rd_ctrl
   import bst_pkg::*;
#(
   parameter int unsigned W           = 8,
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned START_LEVEL = 2,
   localparam int unsigned LW         = $clog2(DEPTH + 1),
   localparam int unsigned CW         = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          halt,
   input  logic [LW-1:0] level,
   input  logic          empty,
   output logic          pop,
   output logic          udf,
   output logic          running
);
   localparam logic [LW-1:0] LVL_START = LW'(START_LEVEL);
   localparam logic [CW-1:0] CNT_LAST  = CW'(W - 1);

   rd_state_e     state_q;
   logic [CW-1:0] bit_cnt_q;
   logic          at_boundary;

   assign at_boundary = (bit_cnt_q == CNT_LAST);
   assign running     = (state_q == RD_RUN);

   always_comb begin
      pop = 1'b0;
      udf = 1'b0;
      if (!halt) begin
         case (state_q)
            RD_WAIT: pop = (level >= LVL_START);
            RD_RUN: begin
               if (at_boundary) begin
                  pop = !empty;
                  udf = empty;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RD_WAIT;
         bit_cnt_q <= '0;
      end else if (clr) begin
         state_q   <= RD_WAIT;
         bit_cnt_q <= '0;
      end else if (halt) begin
         state_q   <= RD_HALT;
         bit_cnt_q <= '0;
      end else begin
         case (state_q)
            RD_WAIT: begin
               bit_cnt_q <= '0;
               if (pop) state_q <= RD_RUN;
            end
            RD_RUN: begin
               bit_cnt_q <= at_boundary ? '0 : bit_cnt_q + 1'b1;
               if (udf) state_q <= RD_HALT;
            end
            default: bit_cnt_q <= '0;
         endcase
      end
   end
endmodule

// File: rtl/bst_shifter.sv
`timescale 1ns/1ps
module bst_shifter #(
   parameter int unsigned W         = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         kill,
   input  logic         load,
   input  logic [W-1:0] load_word,
   input  logic         load_flag,
   output logic         ser_out,
   output logic         flag_out
);
   logic [W-1:0] sreg_q;
   logic [W-1:0] sreg_shifted;

   if (MSB_FIRST) begin : g_msb
      assign sreg_shifted = {sreg_q[W-2:0], 1'b0};
      assign ser_out      = sreg_q[W-1];
   end else begin : g_lsb
      assign sreg_shifted = {1'b0, sreg_q[W-1:1]};
      assign ser_out      = sreg_q[0];
   end

   // flag is a flop loaded with the word, so it moves only at word starts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q   <= '0;
         flag_out <= 1'b0;
      end else if (kill) begin
         sreg_q   <= '0;
         flag_out <= 1'b0;
      end else if (load) begin
         sreg_q   <= load_word;
         flag_out <= load_flag;
      end else begin
         sreg_q   <= sreg_shifted;
      end
   end
endmodule

// File: rtl/burst_ser_tx.sv
`timescale 1ns/1ps
module burst_ser_tx #(
   parameter int unsigned W           = 8,
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned START_LEVEL = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fifo_rst,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         wr_burst,
   output logic         ser_out,
   output logic         burst_out,
   output logic         fifo_err
);
   localparam int unsigned EW = W + 1;
   localparam int unsigned LW = $clog2(DEPTH + 1);

   if (W < 2) begin : g_bad_width
      $error("burst_ser_tx: W must be at least 2");
   end
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("burst_ser_tx: DEPTH must be a power of two, at least 2");
   end
   if ((START_LEVEL < 1) || (START_LEVEL > DEPTH)) begin : g_bad_start
      $error("burst_ser_tx: START_LEVEL must lie in 1..DEPTH");
   end

   logic          fifo_full;
   logic          fifo_empty;
   logic [LW-1:0] fifo_level;
   logic [EW-1:0] head_word;
   logic          rd_pop;
   logic          rd_udf;
   logic          rd_running;
   logic          wr_try;
   logic          wr_push;
   logic          wr_ovf;
   logic          err_q;
   logic          blank;

   assign wr_try  = wr_en && !fifo_rst && !err_q;
   assign wr_push = wr_try && (!fifo_full || rd_pop);
   assign wr_ovf  = wr_try && fifo_full && !rd_pop;
   assign blank   = fifo_rst || err_q || wr_ovf || rd_udf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else if (fifo_rst)
         err_q <= 1'b0;
      else if (wr_ovf || rd_udf)
         err_q <= 1'b1;
   end

   assign fifo_err = err_q;

   bst_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fifo_rst),
      .push      (wr_push),
      .pop       (rd_pop),
      .push_word ({wr_burst, wr_data}),
      .head_word (head_word),
      .level     (fifo_level),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   bst_rd_ctrl #(.W(W), .DEPTH(DEPTH), .START_LEVEL(START_LEVEL)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fifo_rst),
      .halt    (err_q),
      .level   (fifo_level),
      .empty   (fifo_empty),
      .pop     (rd_pop),
      .udf     (rd_udf),
      .running (rd_running)
   );

   bst_shifter #(.W(W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .kill      (blank),
      .load      (rd_pop),
      .load_word (head_word[W-1:0]),
      .load_flag (head_word[W]),
      .ser_out   (ser_out),
      .flag_out  (burst_out)
   );
endmodule

// File: rtl/burst_ser_tx_chk.sv
`timescale 1ns/1ps
module burst_ser_tx_chk #(
   parameter int unsigned DEPTH       = 4,
   parameter int unsigned START_LEVEL = 2,
   localparam int unsigned LW         = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fifo_rst,
   input logic          wr_en,
   input logic          ser_out,
   input logic          burst_out,
   input logic          fifo_err,
   input logic          full,
   input logic          pop,
   input logic [LW-1:0] level,
   input logic          running
);
   localparam logic [LW-1:0] LVL_CAP   = LW'(DEPTH);
   localparam logic [LW-1:0] LVL_START = LW'(START_LEVEL);

   // R2: the flag only turns on in the clock after a word was taken
   p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(burst_out) |-> $past(pop));

   // R3: reading begins only with enough entries queued
   p_start_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> ($past(level) >= LVL_START));

   // R4: occupancy never exceeds the depth
   p_level_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_CAP);

   // R4: a write into a full queue without a read raises the error
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !fifo_rst && !fifo_err && full && !pop) |=> fifo_err);

   // R6: error blanks both outputs
   p_err_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_err |-> (!burst_out && !ser_out));

   // R7: FIFO reset clears error and outputs one clock later
   p_rst_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst |=> (!burst_out && !ser_out && !fifo_err));

   // R8: error is sticky until FIFO reset
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_err && !fifo_rst) |=> fifo_err);
endmodule

bind burst_ser_tx burst_ser_tx_chk #(.DEPTH(DEPTH), .START_LEVEL(START_LEVEL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fifo_rst  (fifo_rst),
   .wr_en     (wr_en),
   .ser_out   (ser_out),
   .burst_out (burst_out),
   .fifo_err  (fifo_err),
   .full      (fifo_full),
   .pop       (rd_pop),
   .level     (fifo_level),
   .running   (rd_running)
);

// File: tb/burst_ser_tx_tb.sv
`timescale 1ns/1ps
module burst_ser_tx_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         fifo_rst;
   logic         wr_en;
   logic [W-1:0] wr_data;
   logic         wr_burst;
   logic         ser_out;
   logic         burst_out;
   logic         fifo_err;

   always #4 clk = ~clk;   // 125 MHz

   burst_ser_tx u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_rst  (fifo_rst),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wr_burst  (wr_burst),
      .ser_out   (ser_out),
      .burst_out (burst_out),
      .fifo_err  (fifo_err)
   );

   int n_chk  = 0;
   int n_fail = 0;

   logic [W:0] exp_q[$];
   logic [W:0] src_q[$];
   bit         sb_on     = 1'b0;
   int         committed = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // writes accepted since the last FIFO reset (bench's own count)
   always @(posedge clk) begin
      if (!rst_n || fifo_rst) committed = 0;
      else if (wr_en)         committed = committed + 1;
   end

   // scoreboard monitor: one bit per clock, MSB first, flag held per word
   logic [W:0] cur;
   int         bitn    = 0;
   bit         running = 1'b0;
   bit         pend    = 1'b0;
   bit         begun   = 1'b0;

   always @(negedge clk) begin
      if (!sb_on) begin
         running = 1'b0;
         pend    = 1'b0;
         begun   = 1'b0;
      end else begin
         if (running) begin
            bitn--;
            if (bitn < 0) begin
               if (exp_q.size() > 0) begin
                  cur  = exp_q.pop_front();
                  bitn = W - 1;
               end else begin
                  running = 1'b0;
               end
            end
         end else if (pend) begin
            cur     = exp_q.pop_front();
            bitn    = W - 1;
            running = 1'b1;
            pend    = 1'b0;
         end else if (!begun && committed >= 2) begin
            pend  = 1'b1;
            begun = 1'b1;
         end
         if (running) begin
            check("R1", "ser_out bit", int'(ser_out), int'(cur[bitn]));
            check("R2", "burst_out", int'(burst_out), int'(cur[W]));
         end
      end
   end

   task automatic put(input logic [W-1:0] d, input logic b);
      wr_en    = 1'b1;
      wr_data  = d;
      wr_burst = b;
      if (sb_on) exp_q.push_back({b, d});
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_src(input int idle_from);
      foreach (src_q[i]) begin
         put(src_q[i][W-1:0], src_q[i][W]);
         if (i >= idle_from) idle(W - 1);
      end
   endtask

   task automatic wait_drain();
      while (!(begun && !running)) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      report();
      $finish;
   end

   initial begin
      bit bad;
      rst_n    = 1'b0;
      fifo_rst = 1'b0;
      wr_en    = 1'b0;
      wr_data  = '0;
      wr_burst = 1'b0;
      idle(3);
      check("R9", "ser_out in reset", int'(ser_out), 0);
      check("R9", "burst_out in reset", int'(burst_out), 0);
      rst_n = 1'b1;
      idle(1);
      check("R9", "fifo_err after reset", int'(fifo_err), 0);
      check("R9", "burst_out after reset", int'(burst_out), 0);

      // R3: one queued entry must not start the reader
      sb_on = 1'b1;
      put(8'hFF, 1'b1);
      bad = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (ser_out || burst_out) bad = 1'b1;
         idle(1);
      end
      check("R3", "outputs quiet with one entry", int'(bad), 0);

      // R1/R2: paced stream with varied data and flag patterns
      src_q = '{9'h1A5, 9'h13C, 9'h0FF, 9'h100, 9'h081, 9'h17E, 9'h196, 9'h001, 9'h180};
      run_src(1);
      wait_drain();
      idle(1);
      check("R5", "fifo_err after underflow", int'(fifo_err), 1);
      check("R6", "burst_out with error", int'(burst_out), 0);
      check("R6", "ser_out with error", int'(ser_out), 0);
      sb_on = 1'b0;
      idle(1);

      // R8: writes after an error change nothing
      put(8'hAA, 1'b1);
      put(8'h55, 1'b1);
      put(8'hF0, 1'b1);
      bad = 1'b0;
      for (int k = 0; k < 30; k++) begin
         if (burst_out || ser_out || !fifo_err) bad = 1'b1;
         idle(1);
      end
      check("R8", "error held, outputs blank", int'(bad), 0);

      // R7: FIFO reset clears error; a write during it is dropped
      fifo_rst = 1'b1;
      idle(1);
      check("R7", "fifo_err after fifo_rst", int'(fifo_err), 0);
      check("R7", "burst_out after fifo_rst", int'(burst_out), 0);
      put(8'hC3, 1'b1);
      idle(1);
      fifo_rst = 1'b0;
      exp_q.delete();
      idle(2);
      sb_on = 1'b1;
      idle(1);
      src_q = '{9'h05A, 9'h1E7, 9'h124, 9'h0DB, 9'h1C3};
      run_src(2);
      wait_drain();
      idle(1);
      check("R5", "fifo_err after second drain", int'(fifo_err), 1);
      sb_on = 1'b0;
      idle(1);

      // R4: back-to-back writes; fifth fills, sixth overflows
      fifo_rst = 1'b1;
      idle(1);
      fifo_rst = 1'b0;
      for (int k = 0; k < 5; k++) put(8'(8'h10 + k), 1'b1);
      check("R4", "no error at exactly full", int'(fifo_err), 0);
      put(8'h77, 1'b1);
      check("R4", "fifo_err after overflow", int'(fifo_err), 1);
      check("R6", "burst_out blank on overflow", int'(burst_out), 0);
      idle(3);
      check("R8", "overflow error sticky", int'(fifo_err), 1);
      fifo_rst = 1'b1;
      idle(1);
      fifo_rst = 1'b0;
      check("R7", "fifo_rst clears overflow", int'(fifo_err), 0);

      report();
      $finish;
   end
endmodule